// File: doc/BRIEF.md
# Interrupt-Triggered Memory Transfer Controller

This block moves one data word from memory to memory each time an enabled interrupt source raises its request flag. Every source owns a slot in a vector table in memory. The slot holds the address of that source's six-word transfer descriptor, which gives the mode, the source address, the destination address and a count. The controller reads the slot, fetches the descriptor, copies one word from the source address to the destination address, and stores the updated addresses and count back into the descriptor. All of this happens over a single request/acknowledge memory port.

When the same source fires twice in a row and a read-skip control bit is set, the controller reuses the descriptor it still holds. It skips both the vector read and the descriptor fetch. Clearing the control bit throws the held copy away. Writing the control bit while a transfer runs does not change the decision already made for that transfer.

At the end of each transfer the controller checks the decremented count. If the count is still non-zero, it pulses a clear to the source's request flag. If the count has reached zero, it disables the source and pulses an interrupt to the CPU, and the source flag stays set for the CPU to handle.

Top module: `irq_xfer_ctl`

The sequencer has these states:
- `ST_IDLE`: arbitration.
- `ST_VEC`: vector-table read.
- `ST_DESC`: six descriptor reads.
- `ST_DRD`: data read.
- `ST_DWR`: data write.
- `ST_WB`: three write-backs.
- `ST_DONE`: end action.

The transitions are:
- `ST_IDLE` goes to `ST_VEC` on a request that misses the held copy.
- `ST_IDLE` goes to `ST_DRD` on a request that hits the held copy.
- `ST_VEC` goes to `ST_DESC` on acknowledge.
- `ST_DESC` goes to `ST_DRD` after the sixth acknowledge.
- `ST_DRD` goes to `ST_DWR` on acknowledge.
- `ST_DWR` goes to `ST_WB` on acknowledge.
- `ST_WB` goes to `ST_DONE` after the third acknowledge.
- `ST_DONE` always goes to `ST_IDLE`.

## Requirements
- R1: After reset the controller is idle (`busy`=0), drives no bus request, all enable bits are 0, the read-skip bit is 0, and no clear or CPU interrupt pulse is driven.
- R2: A raised request flag starts a transfer only while that source's enable bit is 1. With the bit at 0, no bus transaction occurs and the flag is left set.
- R3: When several enabled sources request in the same idle cycle, source 0 has the highest priority and the highest-numbered source the lowest. Arbitration happens only in `ST_IDLE`.
- R4: A transfer that does not reuse the held descriptor makes exactly 12 bus transactions, in this order:
  - one read of the vector slot at `VEC_BASE`+source;
  - six reads of the descriptor words at pointer+0 to pointer+5;
  - one data read;
  - one data write;
  - three write-backs.
- R5: The word read from the descriptor's source address (word 2) is written to its destination address (word 3).
- R6: Descriptor word 0, bit 0 makes the source address advance by 1 after the move. Bit 1 of the same word makes the destination address advance by 1. Word 4, the count, is decremented by 1. The new words 2, 3 and 4 are written back to pointer+2, pointer+3 and pointer+4.
- R7: The held descriptor is reused, giving exactly 5 transactions (data read, data write, three write-backs), when all three of these hold:
  - the read-skip bit is 1 at the moment of arbitration;
  - the winning source is the source serviced last;
  - the held copy is valid.
- R8: Writing 0 to the read-skip bit invalidates the held copy, so the next activation makes 12 transactions even after the bit is set to 1 again.
- R9: A read-skip write that lands during a transfer leaves that transfer's transaction count unchanged. When it finishes, that transfer marks the held copy valid only if the bit is 1 at that time.
- R10: Servicing a different source from the one serviced last always makes 12 transactions.
- R11: If the decremented count is non-zero, `src_clr` pulses for one cycle on the serviced source only. No CPU interrupt is raised and the enable bit is kept.
- R12: If the decremented count is zero, the source's enable bit is cleared and `cpu_irq` pulses for one cycle on that source only. The source's request flag is not cleared.
- R13: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Request flags of the interrupt sources |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | NSRC | New enable register value |
| rrs_wr | input | 1 | Write strobe for the read-skip bit |
| rrs_wdata | input | 1 | New read-skip bit value |
| en_q | output | NSRC | Current enable bits |
| rrs_q | output | 1 | Current read-skip bit |
| busy | output | 1 | High whenever the sequencer is not idle |
| src_clr | output | NSRC | One-cycle pulse clearing a source's request flag |
| cpu_irq | output | NSRC | One-cycle CPU interrupt pulse per source |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, ends the access |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The bench counts the bus transactions of every activation. A controller that reuses a stale descriptor after the skip bit was cleared, or after another source ran, shows 5 transactions where 12 are due. A controller that ignores the held copy shows 12 where 5 are due. Skip-bit writes are placed in the middle of running transfers: a design that applies them at once either changes the running transfer's count or loses the validity set by its end. The bench also fires two sources in the same cycle, and runs a count down to zero to confirm the enable drops, the flag survives and the interrupt appears on the right source. After each move it recomputes the source, destination and count words for all four increment modes and checks them against memory.

// File: rtl/ixc_pkg.sv
package ixc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_DESC,
        ST_DRD,
        ST_DWR,
        ST_WB,
        ST_DONE
    } ixc_state_e;

    localparam int DESC_WORDS = 6;
    localparam int WB_WORDS   = 3;

    localparam int WI_MODE_A = 0;
    localparam int WI_MODE_B = 1;
    localparam int WI_SAR    = 2;
    localparam int WI_DAR    = 3;
    localparam int WI_CNT    = 4;
    localparam int WI_CTL    = 5;

    localparam int MB_SRC_INC = 0;
    localparam int MB_DST_INC = 1;

endpackage

// File: rtl/ixc_arbiter.sv
module ixc_arbiter #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [SW-1:0] idx
);

    // Fixed priority: the lowest index wins, because it is assigned last.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = SW'(i);
            end
        end
    end

endmodule

// File: rtl/ixc_enable_reg.sv
module ixc_enable_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    logic [N-1:0] q_nx;

    always_comb begin
        q_nx = wr ? wdata : q;
        q_nx = q_nx & ~clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nx;
        end
    end

endmodule

// File: rtl/ixc_desc_store.sv
module ixc_desc_store
    import ixc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rrs_wr,
    input  logic          rrs_wdata,
    output logic          rrs_q,
    input  logic          claim,
    input  logic [SW-1:0] claim_src,
    output logic          hit,
    input  logic          ptr_ld,
    input  logic [AW-1:0] ptr_in,
    output logic [AW-1:0] ptr,
    input  logic          word_ld,
    input  logic [2:0]    word_idx,
    input  logic [DW-1:0] word_in,
    input  logic          adv,
    input  logic          commit,
    output logic [AW-1:0] sar,
    output logic [AW-1:0] dar,
    output logic [DW-1:0] cnt
);

    logic [DW-1:0] w [DESC_WORDS];
    logic          valid;
    logic [SW-1:0] last_src;

    assign sar = w[WI_SAR][AW-1:0];
    assign dar = w[WI_DAR][AW-1:0];
    assign cnt = w[WI_CNT];
    assign hit = rrs_q && valid && (last_src == claim_src);

    // Read-skip control and the validity of the held copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrs_q    <= 1'b0;
            valid    <= 1'b0;
            last_src <= '0;
        end else begin
            if (claim) begin
                last_src <= claim_src;
                if (!hit) begin
                    valid <= 1'b0;
                end
            end
            if (commit) begin
                valid <= rrs_q;
            end
            if (rrs_wr) begin
                rrs_q <= rrs_wdata;
                if (!rrs_wdata) begin
                    valid <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_ld) begin
            ptr <= ptr_in;
        end
    end

    // One register per descriptor word.
    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                w[g] <= '0;
            end else if (word_ld && (word_idx == 3'(g))) begin
                w[g] <= word_in;
            end else if (adv) begin
                if (g == WI_SAR) begin
                    w[g] <= w[g] + DW'(w[WI_MODE_A][MB_SRC_INC]);
                end else if (g == WI_DAR) begin
                    w[g] <= w[g] + DW'(w[WI_MODE_A][MB_DST_INC]);
                end else if (g == WI_CNT) begin
                    w[g] <= w[g] - DW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/irq_xfer_ctl.sv
module irq_xfer_ctl
    import ixc_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int VEC_BASE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            rrs_wr,
    input  logic            rrs_wdata,
    output logic [NSRC-1:0] en_q,
    output logic            rrs_q,
    output logic            busy,
    output logic [NSRC-1:0] src_clr,
    output logic [NSRC-1:0] cpu_irq,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    ixc_state_e    state, state_nx;
    logic [SW-1:0] cur_src;
    logic [2:0]    idx;
    logic [DW-1:0] dbuf;

    logic          arb_any;
    logic [SW-1:0] arb_idx;
    logic          hit;
    logic          grant;

    logic [AW-1:0] ptr, sar, dar;
    logic [DW-1:0] cnt;
    logic          ptr_ld, word_ld, adv, commit;
    logic [NSRC-1:0] en_clr;
    logic [NSRC-1:0] src_onehot;

    ixc_arbiter #(.N(NSRC), .SW(SW)) u_arb (
        .req (src_req & en_q),
        .any (arb_any),
        .idx (arb_idx)
    );

    ixc_enable_reg #(.N(NSRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .clr   (en_clr),
        .q     (en_q)
    );

    ixc_desc_store #(.AW(AW), .DW(DW), .SW(SW)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rrs_wr    (rrs_wr),
        .rrs_wdata (rrs_wdata),
        .rrs_q     (rrs_q),
        .claim     (grant),
        .claim_src (arb_idx),
        .hit       (hit),
        .ptr_ld    (ptr_ld),
        .ptr_in    (mem_rdata[AW-1:0]),
        .ptr       (ptr),
        .word_ld   (word_ld),
        .word_idx  (idx),
        .word_in   (mem_rdata),
        .adv       (adv),
        .commit    (commit),
        .sar       (sar),
        .dar       (dar),
        .cnt       (cnt)
    );

    assign grant      = (state == ST_IDLE) && arb_any;
    assign src_onehot = NSRC'(1) << cur_src;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (arb_any) state_nx = hit ? ST_DRD : ST_VEC;
            ST_VEC:  if (mem_ack) state_nx = ST_DESC;
            ST_DESC: if (mem_ack && (idx == 3'(DESC_WORDS - 1))) state_nx = ST_DRD;
            ST_DRD:  if (mem_ack) state_nx = ST_DWR;
            ST_DWR:  if (mem_ack) state_nx = ST_WB;
            ST_WB:   if (mem_ack && (idx == 3'(WB_WORDS - 1))) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Sequencer datapath: serviced source, word index, data buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src <= '0;
            idx     <= '0;
            dbuf    <= '0;
        end else begin
            if (grant) begin
                cur_src <= arb_idx;
            end
            if (mem_ack && (state == ST_DESC)) begin
                idx <= (idx == 3'(DESC_WORDS - 1)) ? 3'd0 : idx + 3'd1;
            end
            if (mem_ack && (state == ST_WB)) begin
                idx <= (idx == 3'(WB_WORDS - 1)) ? 3'd0 : idx + 3'd1;
            end
            if (mem_ack && (state == ST_DRD)) begin
                dbuf <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        src_clr   = '0;
        cpu_irq   = '0;
        en_clr    = '0;
        ptr_ld    = 1'b0;
        word_ld   = 1'b0;
        adv       = 1'b0;
        commit    = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = AW'(VEC_BASE) + AW'(cur_src);
                ptr_ld   = mem_ack;
            end
            ST_DESC: begin
                mem_req  = 1'b1;
                mem_addr = ptr + AW'(idx);
                word_ld  = mem_ack;
            end
            ST_DRD: begin
                mem_req  = 1'b1;
                mem_addr = sar;
            end
            ST_DWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dar;
                mem_wdata = dbuf;
                adv       = mem_ack;
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ptr + AW'(WI_SAR) + AW'(idx);
                if (idx == 3'd0) begin
                    mem_wdata = DW'(sar);
                end else if (idx == 3'd1) begin
                    mem_wdata = DW'(dar);
                end else begin
                    mem_wdata = cnt;
                end
            end
            ST_DONE: begin
                commit = 1'b1;
                if (cnt == '0) begin
                    cpu_irq = src_onehot;
                    en_clr  = src_onehot;
                end else begin
                    src_clr = src_onehot;
                end
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ixc_checker.sv
module ixc_checker #(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [N-1:0]  src_clr,
    input logic [N-1:0]  cpu_irq,
    input logic [N-1:0]  en_q,
    input logic          en_wr
);

    // R13: the access stays put until it is acknowledged
    a_r13_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R1: no bus traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11 / R12: at most one end action on at most one source
    a_r11_single_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_clr, cpu_irq}));

    // R12: the interrupting source is disabled afterwards
    a_r12_en_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |=> ((en_q & $past(cpu_irq)) == '0));

    // R11: a plain flag clear leaves the enables alone
    a_r11_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_clr != '0) && !en_wr) |=> (en_q == $past(en_q)));

endmodule

bind irq_xfer_ctl ixc_checker #(.N(NSRC), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .src_clr   (src_clr),
    .cpu_irq   (cpu_irq),
    .en_q      (en_q),
    .en_wr     (en_wr)
);

// File: tb/sim_irq_xfer_ctl.sv
`timescale 1ns/1ps
module sim_irq_xfer_ctl;

    localparam int NSRC = 4;
    localparam int AW   = 16;
    localparam int DW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] flags = '0;
    logic [NSRC-1:0] set_p = '0;
    logic [NSRC-1:0] clr_b = '0;
    logic            en_wr = 1'b0;
    logic [NSRC-1:0] en_wdata = '0;
    logic            rrs_wr = 1'b0;
    logic            rrs_wdata = 1'b0;
    logic [NSRC-1:0] en_q;
    logic            rrs_q;
    logic            busy;
    logic [NSRC-1:0] src_clr;
    logic [NSRC-1:0] cpu_irq;
    logic            mem_req;
    logic            mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_ack = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;

    logic [15:0] mem [256];

    int nchk = 0, nfail = 0, mchk = 0, mfail = 0;
    int txn = 0, txn_base = 0;
    int irq_cnt [NSRC];
    int clr_cnt [NSRC];
    int irq_base [NSRC];
    int clr_base [NSRC];
    int e_sar [NSRC];
    int e_dar [NSRC];
    int e_cnt [NSRC];
    logic [NSRC-1:0] en_exp = '0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_xfer_ctl #(.NSRC(NSRC), .AW(AW), .DW(DW), .VEC_BASE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req(flags), .en_wr(en_wr), .en_wdata(en_wdata),
        .rrs_wr(rrs_wr), .rrs_wdata(rrs_wdata), .en_q(en_q), .rrs_q(rrs_q), .busy(busy),
        .src_clr(src_clr), .cpu_irq(cpu_irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic int mode_of(int s);
        case (s)
            0: return 3;
            1: return 1;
            2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int desc_ptr(int s);
        return 16 + 8 * s;
    endfunction

    function automatic logic [15:0] init_val(int a);
        int s, w;
        if (a < NSRC) return 16'(desc_ptr(a));
        if (a >= 16 && a < 16 + 8 * NSRC) begin
            s = (a - 16) / 8;
            w = (a - 16) % 8;
            case (w)
                0: return 16'(mode_of(s));
                2: return 16'(100 + 16 * s);
                3: return 16'(180 + 16 * s);
                4: return 16'((s == 0) ? 3 : 5);
                default: return 16'h0;
            endcase
        end
        if (a >= 100 && a < 164) return 16'hA000 + 16'(a - 100);
        return 16'h0;
    endfunction

    // Environment: request flags and a one-wait-state memory
    always @(posedge clk) begin
        flags <= (flags | set_p) & ~clr_b & ~src_clr;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[7:0]];
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            end
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) txn <= txn + 1;
        for (int i = 0; i < NSRC; i++) begin
            if (cpu_irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
            if (src_clr[i]) clr_cnt[i] <= clr_cnt[i] + 1;
        end
    end

    // R13 observed at the ports: a pending access must not move
    logic          p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_wdata = '0;
    always @(negedge clk) begin
        if (rst_n && p_req && !p_ack) begin
            mchk <= mchk + 1;
            if (!(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata)) begin
                mfail <= mfail + 1;
                $display("FAIL R13: actual addr %0d we %0d expected addr %0d we %0d",
                         mem_addr, mem_we, p_addr, p_we);
            end
        end
        p_req   <= mem_req;
        p_ack   <= mem_ack;
        p_we    <= mem_we;
        p_addr  <= mem_addr;
        p_wdata <= mem_wdata;
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic snapshot();
        txn_base = txn;
        for (int i = 0; i < NSRC; i++) begin
            irq_base[i] = irq_cnt[i];
            clr_base[i] = clr_cnt[i];
        end
    endtask

    task automatic write_en(input logic [NSRC-1:0] v);
        @(negedge clk);
        en_wr = 1'b1;
        en_wdata = v;
        en_exp = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic write_rrs(input logic v);
        @(negedge clk);
        rrs_wr = 1'b1;
        rrs_wdata = v;
        @(negedge clk);
        rrs_wr = 1'b0;
    endtask

    task automatic raise(input logic [NSRC-1:0] m);
        @(negedge clk);
        set_p = m;
        @(negedge clk);
        set_p = '0;
    endtask

    // Wait for one transfer; optionally write the skip bit mid-transfer
    task automatic wait_xfer(input int mid);
        int to = 0;
        while (!busy && to < 50) begin
            @(negedge clk);
            to++;
        end
        if (!busy) check("R2 start timeout", 0, 1);
        if (mid >= 0) begin
            @(negedge clk);
            rrs_wr = 1'b1;
            rrs_wdata = (mid != 0);
            @(negedge clk);
            rrs_wr = 1'b0;
        end
        to = 0;
        while (busy && to < 200) begin
            @(negedge clk);
            to++;
        end
        if (busy) check("R4 end timeout", 1, 0);
    endtask

    task automatic verify(input int s, input int exp_txn, input string ttag);
        logic [15:0] dexp;
        int p;
        p = desc_ptr(s);
        dexp = 16'hA000 + 16'(e_sar[s] - 100);
        check({ttag, " transactions"}, txn - txn_base, exp_txn);
        check("R5 moved word", int'(mem[e_dar[s]]), int'(dexp));
        if (mode_of(s) % 2 == 1) e_sar[s]++;
        if (mode_of(s) / 2 == 1) e_dar[s]++;
        e_cnt[s]--;
        check("R6 source word", int'(mem[p + 2]), e_sar[s]);
        check("R6 dest word", int'(mem[p + 3]), e_dar[s]);
        check("R6 count word", int'(mem[p + 4]), e_cnt[s]);
        if (e_cnt[s] == 0) begin
            en_exp[s] = 1'b0;
            check("R12 cpu irq", irq_cnt[s] - irq_base[s], 1);
            check("R12 no flag clear", clr_cnt[s] - clr_base[s], 0);
            check("R12 flag kept", int'(flags[s]), 1);
            check("R12 enable", int'(en_q), int'(en_exp));
        end else begin
            check("R11 flag clear", clr_cnt[s] - clr_base[s], 1);
            check("R11 no irq", irq_cnt[s] - irq_base[s], 0);
            check("R11 flag", int'(flags[s]), 0);
            check("R11 enable", int'(en_q), int'(en_exp));
        end
        snapshot();
    endtask

    task automatic fire(input int s, input int mid, input int exp_txn, input string ttag);
        snapshot();
        raise(NSRC'(1) << s);
        wait_xfer(mid);
        verify(s, exp_txn, ttag);
    endtask

    initial begin
        for (int i = 0; i < NSRC; i++) begin
            irq_cnt[i] = 0;
            clr_cnt[i] = 0;
            e_sar[i] = 100 + 16 * i;
            e_dar[i] = 180 + 16 * i;
            e_cnt[i] = (i == 0) ? 3 : 5;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 mem_req", int'(mem_req), 0);
        check("R1 enables", int'(en_q), 0);
        check("R1 skip bit", int'(rrs_q), 0);
        check("R1 pulses", int'({src_clr, cpu_irq}), 0);

        write_rrs(1'b1);
        // R2: a flag with the enable at 0 does nothing
        snapshot();
        raise(4'b0001);
        repeat (20) @(negedge clk);
        check("R2 no bus traffic", txn - txn_base, 0);
        check("R2 flag kept", int'(flags[0]), 1);
        // enabling lets the pending flag start a full transfer
        write_en(4'b0001);
        wait_xfer(-1);
        verify(0, 12, "R4");
        fire(0, -1, 5, "R7");
        write_rrs(1'b0);
        write_rrs(1'b1);
        fire(0, -1, 12, "R8");
        @(negedge clk);
        clr_b = 4'b0001;
        @(negedge clk);
        clr_b = '0;

        // R10: alternating sources never reuse the held copy
        write_en(4'b0110);
        fire(1, -1, 12, "R10");
        fire(1, -1, 5, "R7");
        fire(2, -1, 12, "R10");
        fire(1, -1, 12, "R10");

        // R3: two sources raised in the same cycle
        write_en(4'b1110);
        snapshot();
        raise(4'b1100);
        wait_xfer(-1);
        check("R3 lower source waits", int'(flags[3]), 1);
        verify(2, 12, "R3");
        wait_xfer(-1);
        verify(3, 12, "R3");

        // R9: skip-bit writes during a transfer take effect afterwards
        fire(3, 0, 5, "R9");
        fire(3, 1, 12, "R9");
        fire(3, -1, 5, "R9");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk + mchk, nfail + mfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk + mchk, nfail + mfail);
            $finish;
        end
    end

endmodule